// File: doc/BRIEF.md
# Segment address classifier

This block takes a 32-bit virtual address and decides what happens to it. The address space splits into six regions. The low half of the space is divided at 0x40000000 into two user regions. The high half is divided into four regions of 512 MiB each. Each region takes a 16-bit descriptor from one half of one of three 32-bit segment control words. A descriptor holds:

- a 3-bit access-mode code,
- a flag that makes the region unmapped at error level,
- a 7-bit physical base,
- a 3-bit cache attribute.

The access-mode code and the current privilege level together give one of three outcomes. The access can raise an address error, go to a TLB for translation, or map directly. A direct access gets a physical address, built from the descriptor base and the region's offset bits, and full read, write and execute permission.

The caller presents a request with its address, the privilege level and the three control words, all in the same cycle. The classification appears on registered outputs one clock later. Each request is handled independently, so a new request may be presented on every cycle. The TLB lookup itself is done elsewhere.

Top module: `seg_addr_xlate`

## Requirements
- R1: An address with bit 31 clear uses the user regions. For 0x40000000–0x7FFFFFFF the descriptor is bits 15:0 of control word 2. For 0x00000000–0x3FFFFFFF it is bits 31:16 of control word 2.
- R2: Addresses with bit 31 set select their descriptor from bits 30:29. Value 0 selects control word 1 bits 31:16, value 1 selects control word 1 bits 15:0, value 2 selects control word 0 bits 31:16, and value 3 selects control word 0 bits 15:0.
- R3: At kernel level (privilege code 0), no access raises an address error. Access-mode codes 1, 2 and 3 give a TLB result, and all other codes give a direct result.
- R4: At supervisor level (privilege code 1), codes 0 and 1 give an address error and codes 2, 3 and 4 give a TLB result. All other codes give a direct result.
- R5: At user level (privilege code 2), codes 0, 1, 2 and 5 give an address error and codes 3 and 4 give a TLB result. Codes 6 and 7 give a direct result.
- R6: At error level (privilege code 3), a descriptor with its unmapped flag set always gives a direct result. Otherwise the R3 rules apply. At the other levels the flag has no effect.
- R7: Access-mode code 6 gives a direct result at every privilege level.
- R8: A direct result has physical address (base placed at bits 35:29 and truncated to 32 bits, with the offset bits cleared) OR (address AND offset mask). The offset mask is 0x3FFFFFFF in the user regions and 0x1FFFFFFF elsewhere. The permission vector is 3'b111, with bit 0 for read, bit 1 for write and bit 2 for execute.
- R9: For a TLB or address-error result, the physical address and permission outputs are zero.
- R10: The result appears with `res_valid` high exactly one clock after a request. A cycle without a request leaves `res_valid` low the next cycle. The data outputs then keep their previous values, whatever the other inputs do.
- R11: The result-code field is 0 for direct, 1 for TLB and 2 for address error. `res_cattr` carries bits 2:0 of the selected descriptor for every result.
- R12: While `rst_n` is low all outputs are zero. Reset takes effect at once and is released through a two-stage synchronizer.

Descriptor layout: bits 15:9 hold the physical base, bits 8:7 are ignored, bits 6:4 hold the access-mode code, bit 3 is the unmapped flag and bits 2:0 hold the cache attribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 32 | Virtual address |
| priv_mode | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 error level |
| seg_ctl0 | input | 32 | Descriptors for 0xC0000000–0xFFFFFFFF |
| seg_ctl1 | input | 32 | Descriptors for 0x80000000–0xBFFFFFFF |
| seg_ctl2 | input | 32 | Descriptors for the two user regions |
| res_valid | output | 1 | Result registered from the previous cycle's request |
| res_code | output | 2 | 0 direct, 1 TLB, 2 address error |
| res_paddr | output | 32 | Physical address for a direct result, else zero |
| res_perm | output | 3 | Read/write/execute permission, else zero |
| res_cattr | output | 3 | Cache attribute of the selected descriptor |

## Verification
The bench builds the block with its default 32-bit address width. At that width every region boundary can be hit with a single address: 0x3FFFFFFF/0x40000000, 0x7FFFFFFF/0x80000000 and each 512 MiB step above. Each stimulus fills every descriptor except the targeted one with a decoy, so a wrong half-word selection shows up in the code, address or cache attribute. Only base bits 11:9 survive the truncation to 32 bits, so the bench uses bases whose low three bits differ. This makes the cleared and kept base bits visible in both region sizes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_ERRL = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    RES_DIRECT   = 2'd0,
    RES_TLB      = 2'd1,
    RES_ADDR_ERR = 2'd2
  } res_e;

  // descriptor field geometry
  localparam int DESC_W   = 16;
  localparam int PB_W     = 7;
  localparam int PB_LSB   = 9;
  localparam int RSV_LSB  = 7;
  localparam int AM_W     = 3;
  localparam int AM_LSB   = 4;
  localparam int EU_BIT   = 3;
  localparam int CA_W     = 3;
  localparam int CA_LSB   = 0;
  localparam int PB_SHIFT = 20;
  localparam int PERM_W   = 3;
  localparam int N_CTL    = 3;
  localparam int CTL_W    = 2 * DESC_W;
  localparam int AM_CODES = 1 << AM_W;

  typedef struct packed {
    logic [PB_W-1:0] pbase;
    logic [AM_W-1:0] amode;
    logic            erl_unmap;
    logic [CA_W-1:0] cattr;
  } seg_desc_t;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/seg_region_pick.sv
module seg_region_pick
  import seg_xlate_pkg::*;
(
  input  logic [2:0]                  addr_top,
  input  logic [N_CTL-1:0][CTL_W-1:0] ctl_regs,
  output seg_desc_t                   desc,
  output logic                        wide_region
);

  localparam int N_HALF = 2 * N_CTL;
  localparam int IDX_W  = $clog2(N_HALF);

  logic [DESC_W-1:0] halves [N_HALF];
  logic [IDX_W-1:0]  idx;
  logic [DESC_W-1:0] raw;
  logic              unused_rsvd;

  // half 2g is the low 16 bits of word g, half 2g+1 its high 16 bits
  generate
    for (genvar g = 0; g < N_CTL; g++) begin : g_word
      assign halves[2*g]   = ctl_regs[g][DESC_W-1:0];
      assign halves[2*g+1] = ctl_regs[g][CTL_W-1:DESC_W];
    end
  endgenerate

  always_comb begin
    if (!addr_top[2]) begin
      wide_region = 1'b1;
      idx = addr_top[1] ? IDX_W'(N_HALF - 2) : IDX_W'(N_HALF - 1);
    end else begin
      wide_region = 1'b0;
      idx = IDX_W'(2'd3 - addr_top[1:0]);
    end
  end

  assign raw = halves[idx];

  assign desc.pbase     = raw[PB_LSB +: PB_W];
  assign desc.amode     = raw[AM_LSB +: AM_W];
  assign desc.erl_unmap = raw[EU_BIT];
  assign desc.cattr     = raw[CA_LSB +: CA_W];

  assign unused_rsvd = ^raw[RSV_LSB +: 2];

endmodule

// File: rtl/seg_mode_decode.sv
module seg_mode_decode
  import seg_xlate_pkg::*;
(
  input  priv_e           priv,
  input  logic [AM_W-1:0] amode,
  input  logic            erl_unmap,
  output res_e            outcome
);

  // bit n of a mask covers access-mode code n
  localparam logic [AM_CODES-1:0] KERN_ERR = 8'b0000_0000;
  localparam logic [AM_CODES-1:0] KERN_MAP = 8'b0000_1110;
  localparam logic [AM_CODES-1:0] SUPV_ERR = 8'b0000_0011;
  localparam logic [AM_CODES-1:0] SUPV_MAP = 8'b0001_1100;
  localparam logic [AM_CODES-1:0] USER_ERR = 8'b0010_0111;
  localparam logic [AM_CODES-1:0] USER_MAP = 8'b0001_1000;

  logic [AM_CODES-1:0] err_mask;
  logic [AM_CODES-1:0] map_mask;
  logic                bypass;

  always_comb begin
    err_mask = KERN_ERR;
    map_mask = KERN_MAP;
    bypass   = 1'b0;
    unique case (priv)
      PRIV_SUPV: begin
        err_mask = SUPV_ERR;
        map_mask = SUPV_MAP;
      end
      PRIV_USER: begin
        err_mask = USER_ERR;
        map_mask = USER_MAP;
      end
      PRIV_ERRL: bypass = erl_unmap;
      default:   bypass = 1'b0;
    endcase
  end

  always_comb begin
    if (bypass) begin
      outcome = RES_DIRECT;
    end else if (err_mask[amode]) begin
      outcome = RES_ADDR_ERR;
    end else if (map_mask[amode]) begin
      outcome = RES_TLB;
    end else begin
      outcome = RES_DIRECT;
    end
  end

endmodule

// File: rtl/seg_phys_form.sv
module seg_phys_form
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int USER_OFS = 30,
  parameter int SEG_OFS  = 29
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [PB_W-1:0]   pbase,
  input  logic              wide_region,
  output logic [ADDR_W-1:0] paddr
);

  localparam int BASE_POS = PB_LSB + PB_SHIFT;
  localparam logic [ADDR_W-1:0] USER_MASK = {{(ADDR_W-USER_OFS){1'b0}}, {USER_OFS{1'b1}}};
  localparam logic [ADDR_W-1:0] SEG_MASK  = {{(ADDR_W-SEG_OFS){1'b0}},  {SEG_OFS{1'b1}}};

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs_mask;

  always_comb begin
    base     = ADDR_W'(pbase) << BASE_POS;
    ofs_mask = wide_region ? USER_MASK : SEG_MASK;
    paddr    = (base & ~ofs_mask) | (vaddr & ofs_mask);
  end

endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        priv_mode,
  input  logic [31:0]       seg_ctl0,
  input  logic [31:0]       seg_ctl1,
  input  logic [31:0]       seg_ctl2,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [2:0]        res_perm,
  output logic [2:0]        res_cattr
);

  logic                        rst_sync_n;
  logic [N_CTL-1:0][CTL_W-1:0] ctl_all;
  seg_desc_t                   sel_desc;
  logic                        wide_region;
  res_e                        outcome;
  logic [ADDR_W-1:0]           direct_pa;

  logic              valid_d, valid_q;
  logic              load_en;
  logic [1:0]        code_d, code_q;
  logic [ADDR_W-1:0] pa_d, pa_q;
  logic [PERM_W-1:0] perm_d, perm_q;
  logic [CA_W-1:0]   ca_d, ca_q;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctl_all = {seg_ctl2, seg_ctl1, seg_ctl0};

  seg_region_pick u_pick (
    .addr_top    (req_addr[ADDR_W-1 -: 3]),
    .ctl_regs    (ctl_all),
    .desc        (sel_desc),
    .wide_region (wide_region)
  );

  seg_mode_decode u_dec (
    .priv      (priv_e'(priv_mode)),
    .amode     (sel_desc.amode),
    .erl_unmap (sel_desc.erl_unmap),
    .outcome   (outcome)
  );

  seg_phys_form #(.ADDR_W(ADDR_W)) u_pa (
    .vaddr       (req_addr),
    .pbase       (sel_desc.pbase),
    .wide_region (wide_region),
    .paddr       (direct_pa)
  );

  // next-state
  always_comb begin
    valid_d = req_valid;
    load_en = req_valid;
    code_d  = outcome;
    ca_d    = sel_desc.cattr;
    if (outcome == RES_DIRECT) begin
      pa_d   = direct_pa;
      perm_d = '1;
    end else begin
      pa_d   = '0;
      perm_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      ca_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        code_q <= code_d;
        pa_q   <= pa_d;
        perm_q <= perm_d;
        ca_q   <= ca_d;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_code  = code_q;
  assign res_paddr = pa_q;
  assign res_perm  = perm_q;
  assign res_cattr = ca_q;

  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> res_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!res_valid && $stable(res_paddr) && $stable(res_code))); // R10
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_code != 2'd0) |-> (res_paddr == '0 && res_perm == '0)); // R9
  AST_DIRECT_FULL_PERM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && res_code == 2'd0) |-> res_perm == 3'b111); // R8
  AST_KERNEL_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && priv_mode == 2'd0) |=> res_code != 2'd2); // R3
  AST_RESERVED_CODE_DIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && sel_desc.amode == 3'd6) |=> res_code == 2'd0); // R7
  AST_ERRL_UNMAP_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && priv_mode == 2'd3 && sel_desc.erl_unmap) |=> res_code == 2'd0); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> res_code != 2'd3); // R11

endmodule

// File: tb/sim_seg_addr_xlate.sv
`timescale 1ns/1ps
module sim_seg_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  priv_mode;
  logic [31:0] seg_ctl0, seg_ctl1, seg_ctl2;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [31:0] res_paddr;
  logic [2:0]  res_perm;
  logic [2:0]  res_cattr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  seg_addr_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .priv_mode(priv_mode), .seg_ctl0(seg_ctl0), .seg_ctl1(seg_ctl1), .seg_ctl2(seg_ctl2),
    .res_valid(res_valid), .res_code(res_code), .res_paddr(res_paddr),
    .res_perm(res_perm), .res_cattr(res_cattr)
  );

  // vector: priv[49:48] addr[47:16] amode[15:13] eu[12] pbase[11:5] cattr[4:2] code[1:0]
  localparam int NV = 30;
  localparam logic [49:0] VECS [NV] = '{
    {2'd0, 32'h1234_5678, 3'd0, 1'b0, 7'h05, 3'd1, 2'd0},
    {2'd0, 32'h5000_1000, 3'd1, 1'b0, 7'h06, 3'd2, 2'd1},
    {2'd0, 32'h8000_0040, 3'd2, 1'b0, 7'h07, 3'd3, 2'd1},
    {2'd0, 32'hA123_4567, 3'd3, 1'b0, 7'h01, 3'd4, 2'd1},
    {2'd0, 32'hC000_0000, 3'd4, 1'b0, 7'h03, 3'd6, 2'd0},
    {2'd0, 32'hFFFF_FFFF, 3'd7, 1'b0, 7'h02, 3'd7, 2'd0},
    {2'd0, 32'hE000_0010, 3'd6, 1'b0, 7'h7E, 3'd0, 2'd0},
    {2'd1, 32'h9000_0000, 3'd0, 1'b0, 7'h01, 3'd1, 2'd2},
    {2'd1, 32'hB000_0000, 3'd1, 1'b0, 7'h02, 3'd2, 2'd2},
    {2'd1, 32'h3000_0000, 3'd2, 1'b0, 7'h03, 3'd3, 2'd1},
    {2'd1, 32'h6000_0000, 3'd3, 1'b0, 7'h04, 3'd4, 2'd1},
    {2'd1, 32'hD000_0000, 3'd4, 1'b0, 7'h05, 3'd6, 2'd1},
    {2'd1, 32'hF000_0000, 3'd5, 1'b0, 7'h06, 3'd7, 2'd0},
    {2'd1, 32'h0000_0004, 3'd6, 1'b0, 7'h7F, 3'd1, 2'd0},
    {2'd1, 32'h7FFF_FFFF, 3'd7, 1'b0, 7'h02, 3'd2, 2'd0},
    {2'd2, 32'h0000_0000, 3'd0, 1'b0, 7'h01, 3'd3, 2'd2},
    {2'd2, 32'h4000_0000, 3'd1, 1'b0, 7'h02, 3'd4, 2'd2},
    {2'd2, 32'h8000_0000, 3'd2, 1'b0, 7'h03, 3'd6, 2'd2},
    {2'd2, 32'hA000_0000, 3'd3, 1'b0, 7'h04, 3'd7, 2'd1},
    {2'd2, 32'hC000_0000, 3'd4, 1'b0, 7'h05, 3'd1, 2'd1},
    {2'd2, 32'hE000_0000, 3'd5, 1'b0, 7'h06, 3'd2, 2'd2},
    {2'd2, 32'h1234_0000, 3'd6, 1'b0, 7'h07, 3'd3, 2'd0},
    {2'd2, 32'h9FFF_FFFF, 3'd7, 1'b0, 7'h01, 3'd4, 2'd0},
    {2'd3, 32'h8000_0000, 3'd1, 1'b1, 7'h02, 3'd6, 2'd0},
    {2'd3, 32'h8000_0000, 3'd1, 1'b0, 7'h03, 3'd7, 2'd1},
    {2'd3, 32'h2000_0000, 3'd3, 1'b1, 7'h04, 3'd1, 2'd0},
    {2'd3, 32'h5000_0000, 3'd2, 1'b0, 7'h05, 3'd2, 2'd1},
    {2'd3, 32'hBFFF_FFFF, 3'd0, 1'b0, 7'h06, 3'd3, 2'd0},
    {2'd0, 32'hDFFF_FFFF, 3'd2, 1'b1, 7'h07, 3'd4, 2'd1},
    {2'd2, 32'h3FFF_FFFF, 3'd7, 1'b0, 7'h7F, 3'd5, 2'd0}
  };

  // decoy descriptor: base 0x55, access mode 0, cache attribute 5
  localparam logic [15:0] DECOY = 16'hAA05;

  function automatic string mode_tag(input logic [1:0] p);
    case (p)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // R8 formula from the requirement text
  function automatic logic [31:0] exp_pa(input logic [31:0] a, input logic [6:0] pb);
    logic [31:0] m;
    logic [31:0] b;
    m = a[31] ? 32'h1FFF_FFFF : 32'h3FFF_FFFF;
    b = 32'(pb) << 29;
    return (b & ~m) | (a & m);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // place a descriptor in the half chosen by R1/R2, decoys elsewhere
  task automatic load_desc(input logic [31:0] a, input logic [15:0] d);
    seg_ctl0 = {DECOY, DECOY};
    seg_ctl1 = {DECOY, DECOY};
    seg_ctl2 = {DECOY, DECOY};
    if (!a[31]) begin
      if (a[30]) seg_ctl2[15:0] = d; else seg_ctl2[31:16] = d;
    end else begin
      case (a[30:29])
        2'd0: seg_ctl1[31:16] = d;
        2'd1: seg_ctl1[15:0]  = d;
        2'd2: seg_ctl0[31:16] = d;
        default: seg_ctl0[15:0] = d;
      endcase
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=<5000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] last_pa;
    logic [1:0]  last_code;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    priv_mode = '0;
    seg_ctl0 = '0;
    seg_ctl1 = '0;
    seg_ctl2 = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(res_valid == 0 && res_code == 0 && res_paddr == 0 && res_perm == 0 && res_cattr == 0,
          "R12 reset outputs", {res_valid, res_code, res_perm, res_cattr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk, one request per cycle
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      logic [31:0] a;
      logic [1:0]  ec;
      v = VECS[i];
      a = v[47:16];
      ec = v[1:0];
      priv_mode = v[49:48];
      req_addr = a;
      load_desc(a, {v[11:5], 2'b11, v[15:13], v[12], v[4:2]});
      req_valid = 1'b1;
      @(negedge clk);
      // R10 result one cycle later; R1 R2 selection through decoys
      check(res_valid == 1'b1, "R10 valid", 32'(res_valid), 32'd1);
      check(res_code == ec, {mode_tag(v[49:48]), " R1 R2 R7 R11 code"}, 32'(res_code), 32'(ec));
      if (ec == 2'd0) begin
        check(res_paddr == exp_pa(a, v[11:5]), "R8 paddr", res_paddr, exp_pa(a, v[11:5]));
        check(res_perm == 3'b111, "R8 perm", 32'(res_perm), 32'h7);
      end else begin
        check(res_paddr == 0 && res_perm == 0, "R9 zeroed", res_paddr | 32'(res_perm), 32'h0);
      end
      check(res_cattr == v[4:2], "R11 cattr", 32'(res_cattr), 32'(v[4:2]));
    end
    last_pa = res_paddr;
    last_code = res_code;

    // R10 idle: no request, inputs change, outputs hold
    req_valid = 1'b0;
    req_addr = 32'h0000_1000;
    priv_mode = 2'd2;
    load_desc(req_addr, 16'h0000);
    @(negedge clk);
    check(res_valid == 1'b0, "R10 idle valid", 32'(res_valid), 32'd0);
    check(res_paddr == last_pa && res_code == last_code, "R10 hold", res_paddr, last_pa);

    // R6 flag ignored at supervisor level: code 1 with flag set still errors
    req_valid = 1'b1;
    priv_mode = 2'd1;
    req_addr = 32'h8800_0000;
    load_desc(req_addr, {7'h01, 2'b00, 3'd1, 1'b1, 3'd2});
    @(negedge clk);
    check(res_code == 2'd2, "R6 flag ignored", 32'(res_code), 32'd2);

    // R12 asynchronous reset mid-run
    req_valid = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check(res_valid == 0 && res_code == 0 && res_paddr == 0 && res_perm == 0 && res_cattr == 0,
          "R12 async clear", {res_valid, res_code, res_perm, res_cattr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule